// File: doc/BRIEF.md
# Buffered Program Write Loader

This block gathers a burst of data words for a buffered program operation and passes them to an array write engine once the host confirms the operation. The host first writes the setup opcode 0xE8. The address of that write fixes a 32-word aligned window. The next write carries the word count minus one. The data writes follow, each with its own address inside the window. A final write carries the confirm opcode 0xD0. The words wait in an internal buffer of up to 32 entries.

After a good confirm, the block streams the words out one at a time over a valid/ready channel, in the order they were loaded. Each output address is the window base joined with the offset that came with that word. While the stream runs, the block honours only suspend and resume. The status byte reports ready, suspended and the two error bits.

Any violation ends the sequence and sets both error bits. A violation is a count that is too large, an address outside the window, or a wrong opcode in the confirm slot. Those bits stay set until the next setup.

Top module: `bufprog_loader`

## Requirements
- R1: After reset, sts_o reads 0x80 (bit 7 ready set, all other bits clear), busy_o is low and wr_valid_o is low.
- R2: In idle, a command write with data 0xE8 starts a sequence and clears both error bits. Any other command data in idle changes nothing.
- R3: The first write after setup carries the word count minus one. A value above 31 sets sts_o bit 4 (program error) and bit 5 (sequence error), and the block returns to idle.
- R4: Every data write address must share bits [AW-1:5] with the setup address. An address outside that window sets bits 4 and 5 and returns to idle.
- R5: After the declared number of data words, data 0xD0 starts the transfer. Any other value sets bits 4 and 5 and discards the buffer, so no word reaches the output.
- R6: Words leave on wr_data_o/wr_addr_o in load order, one per cycle with wr_valid_o and wr_ready_i both high. The address is the window base with the word's loaded 5-bit offset. Valid, data and address hold steady while ready is low.
- R7: busy_o is high from the confirm until the last word is accepted. sts_o bit 7 is clear while the transfer runs unsuspended.
- R8: During a transfer, command writes other than suspend (0xB0) and resume (0xD0) have no effect.
- R9: Suspend 0xB0 during a transfer drops wr_valid_o and sets sts_o bits 2 and 7. Resume 0xD0 clears bit 2 and continues from the next unsent word.
- R10: Error bits stay set until the next setup, and they are never set while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command write strobe, one cycle per write |
| cmd_addr_i | input | AW | Command write address |
| cmd_data_i | input | DW | Command write data: opcode, count or data word |
| wr_valid_o | output | 1 | Word available for the array writer |
| wr_ready_i | input | 1 | Array writer accepts the word |
| wr_addr_o | output | AW | Array address of the current word |
| wr_data_o | output | DW | Current word |
| busy_o | output | 1 | Transfer pending, including while suspended |
| sts_o | output | 8 | Status: bit 7 ready, 5 sequence error, 4 program error, 2 suspended |

## Verification
The bench streams three kinds of bursts and checks each output word against a queue of expected words:
- a full 32-word burst with ascending offsets and a downstream that is always ready;
- a 1-word burst;
- a burst with descending offsets and a downstream whose ready toggles every cycle.

The descending burst separates load order from address order. The toggling ready shows that a word is neither lost nor duplicated under back-pressure.

The abort cases are run next to these bursts:
- a count of 32;
- an address one word past the window;
- a wrong opcode in the confirm slot.

Each must leave the output silent and set both error bits. A suspend held across a stalled transfer, with stray opcodes mixed in, must resume with the sequence unbroken.

// File: rtl/bufprog_pkg.sv
package bufprog_pkg;
  localparam logic [7:0] OP_SETUP   = 8'hE8;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_DATA,
    ST_CONFIRM,
    ST_XFER
  } bp_state_e;
endpackage

// File: rtl/bufprog_win.sv
module bufprog_win #(
  parameter int AW    = 24,
  parameter int IDX_W = 5
) (
  input  logic [AW-1:0]       addr_i,
  input  logic [AW-IDX_W-1:0] base_i,
  output logic                in_win_o
);
  assign in_win_o = (addr_i[AW-1:IDX_W] == base_i);
endmodule

// File: rtl/bufprog_buf.sv
module bufprog_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [IDX_W-1:0] woff_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [IDX_W-1:0] roff_o,
  output logic [DW-1:0]    rdata_o
);
  localparam int EW = DW + IDX_W;

  // each entry: {offset, data}
  logic [EW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= {woff_i, wdata_i};
  end

  assign {roff_o, rdata_o} = mem_q[raddr_i];
endmodule

// File: rtl/bufprog_ctrl.sv
module bufprog_ctrl
  import bufprog_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [AW-1:0]       cmd_addr_i,
  input  logic [DW-1:0]       cmd_data_i,
  input  logic                in_win_i,
  input  logic                wr_ready_i,
  output logic [AW-IDX_W-1:0] base_o,
  output logic                buf_we_o,
  output logic [IDX_W-1:0]    wptr_o,
  output logic [IDX_W-1:0]    rptr_o,
  output logic                wr_valid_o,
  output logic                busy_o,
  output logic                susp_o,
  output logic                err_o
);
  localparam logic [DW-1:0] MAX_CNT = DW'(DEPTH - 1);

  bp_state_e           state_q;
  logic [AW-IDX_W-1:0] base_q;
  logic [IDX_W-1:0]    cnt_q, wptr_q, rptr_q;
  logic                susp_q, err_q;
  logic                op_setup, op_confirm, op_suspend, hs;

  assign op_setup   = cmd_valid_i && (cmd_data_i[7:0] == OP_SETUP)   && (cmd_data_i[DW-1:8] == '0);
  assign op_confirm = cmd_valid_i && (cmd_data_i[7:0] == OP_CONFIRM) && (cmd_data_i[DW-1:8] == '0);
  assign op_suspend = cmd_valid_i && (cmd_data_i[7:0] == OP_SUSPEND) && (cmd_data_i[DW-1:8] == '0);

  assign wr_valid_o = (state_q == ST_XFER) && !susp_q;
  assign hs         = wr_valid_o && wr_ready_i;
  assign buf_we_o   = (state_q == ST_DATA) && cmd_valid_i && in_win_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      cnt_q   <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
      susp_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (op_setup) begin
          base_q  <= cmd_addr_i[AW-1:IDX_W];
          err_q   <= 1'b0;
          state_q <= ST_COUNT;
        end
        ST_COUNT: if (cmd_valid_i) begin
          if (cmd_data_i > MAX_CNT) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cnt_q   <= cmd_data_i[IDX_W-1:0];
            wptr_q  <= '0;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: if (cmd_valid_i) begin
          if (!in_win_i) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (wptr_q == cnt_q) begin
            state_q <= ST_CONFIRM;
          end else begin
            wptr_q <= wptr_q + 1'b1;
          end
        end
        ST_CONFIRM: if (cmd_valid_i) begin
          if (op_confirm) begin
            rptr_q  <= '0;
            susp_q  <= 1'b0;
            state_q <= ST_XFER;
          end else begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_XFER: begin
          if (hs) begin
            if (rptr_q == cnt_q) state_q <= ST_IDLE;
            else                 rptr_q  <= rptr_q + 1'b1;
          end
          // only suspend/resume are honoured here
          if (op_suspend && !susp_q)     susp_q <= 1'b1;
          else if (op_confirm && susp_q) susp_q <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign base_o = base_q;
  assign wptr_o = wptr_q;
  assign rptr_o = rptr_q;
  assign busy_o = (state_q == ST_XFER);
  assign susp_o = susp_q;
  assign err_o  = err_q;
endmodule

// File: rtl/bufprog_loader.sv
module bufprog_loader #(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_data_i,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          busy_o,
  output logic [7:0]    sts_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [AW-IDX_W-1:0] base;
  logic                in_win, buf_we, susp, err;
  logic [IDX_W-1:0]    wptr, rptr, roff;

  bufprog_win #(.AW(AW), .IDX_W(IDX_W)) u_win (
    .addr_i   (cmd_addr_i),
    .base_i   (base),
    .in_win_o (in_win)
  );

  bufprog_buf #(.DW(DW), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_buf (
    .clk_i   (clk_i),
    .we_i    (buf_we),
    .waddr_i (wptr),
    .woff_i  (cmd_addr_i[IDX_W-1:0]),
    .wdata_i (cmd_data_i),
    .raddr_i (rptr),
    .roff_o  (roff),
    .rdata_o (wr_data_o)
  );

  bufprog_ctrl #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_data_i  (cmd_data_i),
    .in_win_i    (in_win),
    .wr_ready_i  (wr_ready_i),
    .base_o      (base),
    .buf_we_o    (buf_we),
    .wptr_o      (wptr),
    .rptr_o      (rptr),
    .wr_valid_o  (wr_valid_o),
    .busy_o      (busy_o),
    .susp_o      (susp),
    .err_o       (err)
  );

  assign wr_addr_o = {base, roff};
  // bit7 ready, bit5 sequence error, bit4 program error, bit2 suspended
  assign sts_o = {~(busy_o & ~susp), 1'b0, err, err, 1'b0, susp, 2'b00};
endmodule

// File: rtl/bufprog_chk.sv
module bufprog_chk #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [DW-1:0] cmd_data_i,
  input logic          wr_valid_o,
  input logic          wr_ready_i,
  input logic [AW-1:0] wr_addr_o,
  input logic [DW-1:0] wr_data_o,
  input logic          busy_o,
  input logic [7:0]    sts_o
);
  logic susp_cmd;
  assign susp_cmd = cmd_valid_i && (cmd_data_i == DW'(8'hB0));

  // R7: the output stream only runs during a pending transfer
  a_r7_valid_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> busy_o);

  // R6: a stalled word holds
  a_r6_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i && !susp_cmd |=>
      wr_valid_o && $stable(wr_data_o) && $stable(wr_addr_o));

  // R10: error and busy exclude each other
  a_r10_err_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o[5] |-> !busy_o);

  // R9: suspended means no output and ready
  a_r9_susp_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o[2] |-> !wr_valid_o && sts_o[7] && busy_o);

  // R9: suspend request stops the stream next cycle
  a_r9_susp_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && susp_cmd |=> !wr_valid_o);

  // R10: errors only appear after a word of input
  a_r10_err_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o[4]) |-> $past(cmd_valid_i));
endmodule

bind bufprog_loader bufprog_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_data_i  (cmd_data_i),
  .wr_valid_o  (wr_valid_o),
  .wr_ready_i  (wr_ready_i),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o),
  .busy_o      (busy_o),
  .sts_o       (sts_o)
);

// File: tb/bufprog_loader_tb.sv
module bufprog_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          wr_valid, wr_ready, busy;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [7:0]    sts;

  int total = 0;
  int bad = 0;
  int rdy_mode = 0;  // 0 always, 1 toggle, 2 held low
  bit done = 1'b0;
  logic [AW+DW-1:0] exp_q[$];
  int popped = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bufprog_loader #(.AW(AW), .DW(DW), .DEPTH(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_addr_i(cmd_addr),
    .cmd_data_i(cmd_data), .wr_valid_o(wr_valid), .wr_ready_i(wr_ready),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .busy_o(busy), .sts_o(sts)
  );

  always_ff @(posedge clk) begin
    case (rdy_mode)
      0:       wr_ready <= 1'b1;
      1:       wr_ready <= ~wr_ready;
      default: wr_ready <= 1'b0;
    endcase
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: compare each accepted word with the scoreboard
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected word", {wr_addr, wr_data}, 0);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        popped++;
        check({wr_addr, wr_data} == e, "R6 order/addr/data", {wr_addr, wr_data}, e);
      end
    end
  end

  task automatic cmd(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // setup, count, n words; expected pushed only when push=1
  task automatic load(input logic [AW-1:0] start, input int n, input int cnt_field,
                      input bit desc, input int seed, input bit push);
    cmd(start, 16'h00E8);
    cmd(start, DW'(cnt_field));
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = {start[AW-1:5], 5'(desc ? (n - 1 - i) : i)};
      d = DW'(16'hA000 + i * 7 + seed);
      cmd(a, d);
      if (push) exp_q.push_back({a, d});
    end
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    check(!busy, req, busy, 0);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sts == 8'h80 && !busy && !wr_valid, "R1 reset state", {sts, busy, wr_valid}, 16'h200);
    rst_n = 1'b1;

    // R2: stray opcode in idle
    cmd(24'h000100, 16'h00D0);
    check(sts == 8'h80 && !busy, "R2 idle ignores non-setup", sts, 8'h80);

    // full 32-word ascending burst
    rdy_mode = 0;
    load(24'h012340, 32, 31, 1'b0, 1, 1'b1);
    cmd(24'h012340, 16'h00D0);
    check(busy, "R7 busy after confirm", busy, 1);
    drain("R5 R6 full burst drained");
    check(popped == 32, "R6 32 words", popped, 32);

    // single word
    popped = 0;
    load(24'h0000A0, 1, 0, 1'b0, 3, 1'b1);
    cmd(24'h0000A0, 16'h00D0);
    drain("R6 one-word burst");
    check(popped == 1, "R6 one word", popped, 1);

    // descending offsets, toggling ready
    popped = 0;
    rdy_mode = 1;
    load(24'h7FFFE0, 12, 11, 1'b1, 9, 1'b1);
    cmd(24'h7FFFE0, 16'h00D0);
    drain("R6 descending under back-pressure");
    check(popped == 12, "R6 twelve words", popped, 12);
    rdy_mode = 0;

    // count too large
    cmd(24'h000200, 16'h00E8);
    cmd(24'h000200, 16'd32);
    check(sts == 8'hB0 && !busy, "R3 count overflow error", sts, 8'hB0);
    cmd(24'h000200, 16'h00D0);
    check(sts == 8'hB0 && !busy && !wr_valid, "R10 error sticky, idle", sts, 8'hB0);

    // setup clears errors
    cmd(24'h000200, 16'h00E8);
    check(sts == 8'h80, "R2 setup clears errors", sts, 8'h80);
    cmd(24'h000200, 16'd3);
    cmd(24'h000201, 16'h1111);
    cmd(24'h000220, 16'h2222);  // next window
    check(sts == 8'hB0 && !busy, "R4 out-of-window error", sts, 8'hB0);
    cmd(24'h000200, 16'h00D0);
    repeat (3) @(negedge clk);
    check(!busy && !wr_valid, "R4 no transfer after abort", busy, 0);

    // bad confirm
    load(24'h000300, 4, 3, 1'b0, 5, 1'b0);
    cmd(24'h000300, 16'h00FF);
    check(sts == 8'hB0 && !busy, "R5 bad confirm error", sts, 8'hB0);
    cmd(24'h000300, 16'h00D0);
    repeat (3) @(negedge clk);
    check(!busy && !wr_valid && exp_q.size() == 0, "R5 buffer discarded", busy, 0);

    // suspend / resume with stalled sink
    popped = 0;
    rdy_mode = 2;
    load(24'h004400, 16, 15, 1'b0, 11, 1'b1);
    cmd(24'h004400, 16'h00D0);
    check(busy && wr_valid && sts == 8'h00, "R7 running status", sts, 8'h00);
    cmd(24'h004400, 16'h00E8);
    check(busy && wr_valid && sts == 8'h00, "R8 setup ignored while busy", sts, 8'h00);
    cmd(24'h004400, 16'h00B0);
    check(!wr_valid && sts == 8'h84 && busy, "R9 suspended", sts, 8'h84);
    cmd(24'h004400, 16'h0040);
    check(!wr_valid && sts == 8'h84, "R8 R9 stray opcode while suspended", sts, 8'h84);
    rdy_mode = 0;
    repeat (3) @(negedge clk);
    check(popped == 0, "R9 nothing sent while suspended", popped, 0);
    cmd(24'h004400, 16'h00D0);
    check(sts[2] == 1'b0, "R9 resume clears bit 2", sts, 0);
    drain("R9 stream complete after resume");
    check(popped == 16, "R9 sixteen words", popped, 16);
    check(sts == 8'h80, "R7 ready after transfer", sts, 8'h80);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule